// File: doc/BRIEF.md
# UART Receive Byte Queue with Threshold Interrupt

This block sits between a serial deserializer and a host. Each byte that the deserializer reports goes into a 16-entry first-in first-out store. The host reads the bytes back in arrival order and sees how many are waiting. A data-available interrupt is raised only when the number of stored bytes reaches a threshold that the host selects. The host can therefore service the line in bursts instead of once per character.

When the store is full, an incoming byte is refused. The bytes already held are left untouched, and a sticky overrun flag records the loss. That flag stays set until the host performs a status read. Reading an empty store is harmless: the data output keeps its last value and the count does not move.

Top module: `uart_rx_fifo`

## Requirements
- R1: Bytes are returned in the order they arrived. A read strobe on a non-empty store presents the oldest byte on `rd_data` on the clock edge that samples the strobe.
- R2: `irq` is high whenever `irq_en` is high and `count` is at or above the selected threshold. Because it follows the registered count, it changes in the same cycle as `count`.
- R3: `trig_sel` value 0 selects a threshold of 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R4: Bytes continue to be accepted past the threshold until `count` reaches 16, and `count` never exceeds 16.
- R5: A byte that arrives while `count` is 16 is discarded and the stored bytes are not altered. This holds even if a read strobe occurs in the same cycle, in which case the read still removes one byte.
- R6: A byte that arrives while `count` is 16 sets `overrun` on the next clock edge.
- R7: `overrun` stays set until a `status_rd` strobe clears it. If a new overrun and `status_rd` occur in the same cycle, the flag stays set.
- R8: A read strobe while `count` is 0 leaves `rd_data` at its previous value and leaves `count` unchanged.
- R9: A byte write and a read in the same cycle, with the store neither empty nor full, leave `count` unchanged and keep the arrival order.
- R10: A synchronous active-low reset empties the store and clears `overrun`, `irq`, `count` and `rd_data`.
- R11: `irq` drops once reads take `count` below the threshold, or as soon as `irq_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest byte, registered |
| count | output | 5 | Number of stored bytes, 0 to 16 |
| trig_sel | input | 2 | Interrupt threshold select |
| irq_en | input | 1 | Data-available interrupt enable |
| irq | output | 1 | Data-available interrupt |
| status_rd | input | 1 | Host status read, clears overrun |
| overrun | output | 1 | Sticky overrun error flag |

## Verification
The registered outputs `rd_data`, `count` and `overrun` are due one clock edge after the strobe that causes them. `irq` follows `count` in the same cycle, and it follows `trig_sel` or `irq_en` at once. Every stimulus is applied on a falling edge and held for one rising edge, then removed on the next falling edge. Each state check is made just after that falling edge. A monitor samples `rd_data` on the falling edge that follows each accepted read and compares it with the byte it pops from a scoreboard queue. The queue is filled by a reference model of the store, so any byte that is dropped, reordered or corrupted shows up as a mismatch.

// File: rtl/uart_rxq_pkg.sv
// Package: shared helpers for the receive byte queue.
// Assumes the threshold encoding is fixed at four levels.
package uart_rxq_pkg;

    // Map the two-bit threshold select to a byte count.
    function automatic int unsigned level_of(input logic [1:0] sel);
        case (sel)
            2'd0:    level_of = 1;
            2'd1:    level_of = 4;
            2'd2:    level_of = 8;
            default: level_of = 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxq_store.sv
// Module: byte storage array with a registered read port.
// Assumes the controller only asserts the write and read enables when the
// access is legal (not full / not empty). rd_data holds when no read occurs.
module uart_rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Write a byte into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the oldest byte on a legal read; otherwise keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/uart_rxq_ctrl.sv
// Module: pointer, count and overrun control for the receive queue.
// Assumes single-cycle strobes; a write into a full queue is refused and
// recorded as overrun, with overrun winning over a same-cycle clear.
module uart_rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          clr_ovr,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          overrun
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    logic full, empty;

    // Decode legality of each access from the current count.
    always_comb begin
        full  = (count == FULL_CNT);
        empty = (count == '0);
        wr_ok = wr_req && !full;
        rd_ok = rd_req && !empty;
    end

    // Advance the write pointer, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_ptr <= '0;
        else if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Track the fill level from accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (wr_ok && !rd_ok) count <= count + 1'b1;
        else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end

    // Sticky overrun: set on a refused write, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)               overrun <= 1'b0;
        else if (wr_req && full)  overrun <= 1'b1;
        else if (clr_ovr)         overrun <= 1'b0;
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> (count == FULL_CNT));

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req) |=> overrun);

    p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun);

    p_both_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/uart_rxq_irq.sv
// Module: threshold comparison for the data-available interrupt.
// Assumes count is registered upstream, so the output is glitch-free per cycle.
module uart_rxq_irq #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          irq
);
    import uart_rxq_pkg::*;

    logic [CW-1:0] level;

    // Resolve the threshold, clamped to the queue depth.
    always_comb begin
        if (level_of(trig_sel) > DEPTH) level = CW'(DEPTH);
        else                            level = CW'(level_of(trig_sel));
    end

    // Raise the interrupt while enabled and at or above the threshold.
    always_comb irq = irq_en && (count >= level);

    p_irq_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count != '0));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: top of the receive byte queue with threshold interrupt.
// Assumes rx_valid, rd_en and status_rd are one-cycle strobes from
// synchronous logic; reset is synchronous and active low.
module uart_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          irq,
    input  logic          status_rd,
    output logic          overrun
);
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;

    uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (rx_valid),
        .rd_req  (rd_en),
        .clr_ovr (status_rd),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count),
        .overrun (overrun)
    );

    uart_rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (wr_ptr),
        .wr_data (rx_data),
        .rd_en   (rd_ok),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    uart_rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .trig_sel (trig_sel),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == '0) |=> $stable(rd_data));
endmodule

// File: tb/uart_rx_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic [1:0] trig_sel = 2'd0;
    logic       irq_en = 1'b0;
    logic       irq;
    logic       status_rd = 1'b0;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mq[$];      // reference model contents
    logic [7:0] exp_q[$];   // bytes due on rd_data
    logic       rd_exp = 1'b0;
    logic       chk_due = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_fifo u_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_en(rd_en), .rd_data(rd_data), .count(count), .trig_sel(trig_sel),
        .irq_en(irq_en), .irq(irq), .status_rd(status_rd), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: an accepted read is due on rd_data by the next falling edge.
    always @(posedge clk) chk_due <= rd_en && rd_exp;
    always @(negedge clk) begin
        if (chk_due) begin
            #0.5;
            chk("R1 read order", {24'b0, rd_data}, {24'b0, exp_q.pop_front()});
        end
    end

    // Driver: one stimulus cycle, then inputs idle; model updated alongside.
    task automatic step(input bit wr, input logic [7:0] b, input bit rd, input bit srd);
        bit was_full;
        @(negedge clk);
        was_full = (mq.size() == 16);
        rx_valid = wr; rx_data = b; rd_en = rd; status_rd = srd;
        rd_exp = rd && (mq.size() > 0);
        if (rd_exp) exp_q.push_back(mq.pop_front());
        if (wr && !was_full) mq.push_back(b);
        @(negedge clk);
        rx_valid = 0; rd_en = 0; status_rd = 0; rd_exp = 0;
        #1;
    endtask

    task automatic wr_byte(input logic [7:0] b); step(1, b, 0, 0); endtask
    task automatic rd_byte(); step(0, 8'h00, 1, 0); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 count", count, 0);
        chk("R10 irq", irq, 0);
        chk("R10 overrun", overrun, 0);
        chk("R10 rd_data", rd_data, 0);

        // R2/R3 threshold 1
        irq_en = 1; trig_sel = 2'd0; #1;
        chk("R2 irq empty", irq, 0);
        wr_byte(8'h11);
        chk("R3 sel0 level1 irq", irq, 1);
        rd_byte();
        chk("R11 irq drop after read", irq, 0);

        // R3 threshold 4
        trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) wr_byte(8'h20 + 8'(i));
        chk("R3 sel1 below level", irq, 0);
        wr_byte(8'h23);
        chk("R3 sel1 at level", irq, 1);
        irq_en = 0; #1;
        chk("R11 enable low", irq, 0);
        irq_en = 1; #1;
        chk("R2 re-enabled", irq, 1);
        rd_byte();
        chk("R11 below level after read", irq, 0);

        // R9 simultaneous write and read
        step(1, 8'h30, 1, 0);
        chk("R9 count unchanged", count, 3);

        // R4 fill to 16, R3 threshold 8 and 14
        trig_sel = 2'd2; #1;
        chk("R3 sel2 below", irq, 0);
        for (int i = 0; i < 5; i++) wr_byte(8'h40 + 8'(i));
        chk("R3 sel2 at 8", irq, 1);
        trig_sel = 2'd3; #1;
        chk("R3 sel3 at 8", irq, 0);
        for (int i = 0; i < 5; i++) wr_byte(8'h50 + 8'(i));
        chk("R3 sel3 at 13", irq, 0);
        wr_byte(8'h55);
        chk("R3 sel3 at 14", irq, 1);
        wr_byte(8'h56); wr_byte(8'h57);
        chk("R4 count full", count, 16);
        chk("R4 no overrun yet", overrun, 0);

        // R5/R6 write while full
        wr_byte(8'hEE);
        chk("R5 count stays", count, 16);
        chk("R6 overrun set", overrun, 1);
        step(1, 8'hEF, 1, 0);
        chk("R5 read with refused write", count, 15);

        // R7 set wins over clear: refill then full-write with status read
        wr_byte(8'h60);
        step(1, 8'hED, 0, 1);
        chk("R7 set wins over clear", overrun, 1);

        // drain all, order checked by monitor
        while (mq.size() > 0) rd_byte();
        chk("R1 drained count", count, 0);
        chk("R7 still set after drain", overrun, 1);
        step(0, 8'h00, 0, 1);
        chk("R7 cleared by status read", overrun, 0);

        // R8 empty read
        rd_byte();
        chk("R8 rd_data holds", rd_data, 8'h60);
        chk("R8 count stays", count, 0);
        step(1, 8'h70, 1, 0);
        chk("R8 write with empty read", count, 1);
        rd_byte();
        chk("R8 late read data", rd_data, 8'h70);

        // R10 reset mid-fill
        wr_byte(8'h81); wr_byte(8'h82); wr_byte(8'h83);
        wr_byte(8'hEE);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        mq.delete();
        trig_sel = 2'd0; #1;
        chk("R10 count after reset", count, 0);
        chk("R10 irq after reset", irq, 0);
        chk("R10 rd_data after reset", rd_data, 0);
        wr_byte(8'h91); rd_byte();
        chk("R10 fresh order", rd_data, 8'h91);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule